// File: doc/BRIEF.md
# Pulse-Coded Strobe Receiver

This block listens to a single strobe line that goes high once for every read access a host makes to a reserved address window. The host has no write path, so it encodes data in how many reads it issues back to back. The receiver counts strobe rising edges into a burst and closes the burst once the line has been quiet for a programmable number of clocks. It then classifies the burst by its length and shifts the resulting bits into a byte.

Before every byte the host issues a three-strobe probe and looks at the read data it gets back. A nonzero word means an adapter is fitted and can take a byte. An unfitted slot returns the all-zero alias word. The receiver drives that response word. It also flags the arrival of the agreed wake-up code. Once that code has been seen, it splits each later byte into a five-bit function selector and a three-bit option field for the command decoder downstream.

Top module: `strb_rx`

## Requirements
- R1: After reset, byte_valid_o, cmd_valid_o, err_o and link_up_o are 0. resp_o is all ones while sink_ready_i is 1.
- R2: A burst ends when no new strobe rising edge is seen for GAP clock edges after the edge that captured the last one. A completed byte shows on byte_valid_o right after the GAP-th such edge, that is, from the GAP+1-th falling edge after the strobe was raised.
- R3: While a byte is being received, a burst of exactly 1 strobe adds a 1 bit and a burst of exactly 2 strobes adds a 0 bit. Bits arrive most significant first. After the eighth bit, byte_valid_o pulses for one clock with the byte on byte_o.
- R4: resp_o is all ones while the receiver is idle and sink_ready_i is 1. It is all zeros while a byte is in progress or while sink_ready_i is 0.
- R5: A burst of 3 strobes while idle starts a byte only if sink_ready_i is 1. With sink_ready_i at 0 the probe and the bits that follow produce no byte.
- R6: Bursts of 1 or 2 strobes while idle are ignored.
- R7: While a byte is in progress, a burst of 3, or of 5 or more, strobes discards the partial byte, returns to idle and sets err_o. err_o stays set across later good bytes.
- R8: A burst of exactly 4 strobes returns to idle from any state, discards any partial byte and clears err_o.
- R9: link_up_o becomes 1 once a byte equal to 0x90 is received and stays 1 until reset.
- R10: cmd_valid_o pulses with byte_valid_o only for bytes that finish while link_up_o is already 1. In that case cmd_sel_o is byte_o[7:3] and cmd_opt_o is byte_o[2:0].
- R11: A strobe held high for several clocks counts as a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Access strobe from the reserved window, synchronous to clk |
| sink_ready_i | input | 1 | Downstream can accept another byte |
| resp_o | output | RESP_W | Read data returned to the host: all ones = ready |
| byte_valid_o | output | 1 | One-clock pulse when a byte completes |
| byte_o | output | 8 | Last completed byte |
| err_o | output | 1 | Sticky abort flag |
| link_up_o | output | 1 | Wake-up code has been received |
| cmd_valid_o | output | 1 | Byte is a command (link already up) |
| cmd_sel_o | output | 5 | Function selector of the command |
| cmd_opt_o | output | 3 | Option bits of the command |

## Verification
Every result depends on the burst closing, which happens on the GAP-th clock edge after the last captured rising edge. One directed case drops the strobe, counts falling edges until byte_valid_o appears, expects exactly GAP+1, and checks that the pulse is gone one edge later. All other checks of bytes, errors and responses are sampled on a falling edge only after a settle window of GAP+2 quiet clocks, so the registered result has already landed. The response word is combinational from the state and sink_ready_i, and it is sampled on the falling edge that follows such a window.

// File: rtl/strb_rx_pkg.sv
package strb_rx_pkg;

    typedef enum logic [2:0] {
        BK_ONE   = 3'd0,
        BK_ZERO  = 3'd1,
        BK_PROBE = 3'd2,
        BK_CLEAR = 3'd3,
        BK_ODD   = 3'd4
    } burst_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RX   = 1'b1
    } rx_state_e;

    function automatic burst_kind_e classify(input logic [2:0] len);
        case (len)
            3'd1:    return BK_ONE;
            3'd2:    return BK_ZERO;
            3'd3:    return BK_PROBE;
            3'd4:    return BK_CLEAR;
            default: return BK_ODD;
        endcase
    endfunction

endpackage

// File: rtl/strb_burst_gap.sv
module strb_burst_gap #(
    parameter int GAP   = 64,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    output logic             done_o,
    output logic [LEN_W-1:0] len_o
);
    localparam int GAP_W = $clog2(GAP + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP - 1);
    localparam logic [LEN_W-1:0] LEN_MAX  = '1;

    typedef struct packed {
        logic             strb;
        logic             active;
        logic [GAP_W-1:0] gap;
        logic [LEN_W-1:0] len;
    } gap_state_t;

    gap_state_t s_d, s_q;
    logic       rise;
    logic       done;

    always_comb begin
        s_d    = s_q;
        done   = 1'b0;
        rise   = strobe_i & ~s_q.strb;
        s_d.strb = strobe_i;
        if (rise) begin
            s_d.active = 1'b1;
            s_d.gap    = '0;
            if (!s_q.active)
                s_d.len = LEN_W'(1);
            else if (s_q.len != LEN_MAX)
                s_d.len = s_q.len + LEN_W'(1);
        end else if (s_q.active) begin
            if (s_q.gap == GAP_LAST) begin
                done       = 1'b1;
                s_d.active = 1'b0;
                s_d.gap    = '0;
                s_d.len    = '0;
            end else begin
                s_d.gap = s_q.gap + GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = done;
    assign len_o  = s_q.len;

    p_done_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_o != '0));

    p_done_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/strb_byte_fsm.sv
module strb_byte_fsm
    import strb_rx_pkg::*;
#(
    parameter int          RESP_W     = 32,
    parameter logic [7:0]  READY_CODE = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [2:0]        len_i,
    input  logic              sink_ready_i,
    output logic [RESP_W-1:0] resp_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic              err_o,
    output logic              link_up_o,
    output logic              cmd_valid_o
);
    typedef struct packed {
        rx_state_e  state;
        logic [6:0] sh;
        logic [2:0] nbits;
        logic [7:0] data;
        logic       valid;
        logic       cmd_valid;
        logic       err;
        logic       link;
    } fsm_t;

    fsm_t        f_d, f_q;
    burst_kind_e kind;
    logic [7:0]  nxt;

    always_comb begin
        f_d           = f_q;
        f_d.valid     = 1'b0;
        f_d.cmd_valid = 1'b0;
        kind          = classify(len_i);
        nxt           = {f_q.sh, (kind == BK_ONE)};
        if (done_i) begin
            case (f_q.state)
                ST_IDLE: begin
                    if (kind == BK_PROBE && sink_ready_i) begin
                        f_d.state = ST_RX;
                        f_d.nbits = '0;
                    end else if (kind == BK_CLEAR) begin
                        f_d.err = 1'b0;
                    end
                end
                ST_RX: begin
                    case (kind)
                        BK_ONE, BK_ZERO: begin
                            f_d.sh = nxt[6:0];
                            if (f_q.nbits == 3'd7) begin
                                f_d.state     = ST_IDLE;
                                f_d.valid     = 1'b1;
                                f_d.data      = nxt;
                                f_d.cmd_valid = f_q.link;
                                if (nxt == READY_CODE) f_d.link = 1'b1;
                            end else begin
                                f_d.nbits = f_q.nbits + 3'd1;
                            end
                        end
                        BK_CLEAR: begin
                            f_d.state = ST_IDLE;
                            f_d.err   = 1'b0;
                        end
                        default: begin
                            f_d.state = ST_IDLE;
                            f_d.err   = 1'b1;
                        end
                    endcase
                end
                default: f_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign resp_o       = (f_q.state == ST_IDLE && sink_ready_i) ? '1 : '0;
    assign byte_valid_o = f_q.valid;
    assign byte_o       = f_q.data;
    assign err_o        = f_q.err;
    assign link_up_o    = f_q.link;
    assign cmd_valid_o  = f_q.cmd_valid;

    p_valid_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(done_i));

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);

    p_no_resp_after_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && f_q.state == ST_IDLE && len_i == 3'd3 && sink_ready_i)
        |=> (resp_o == '0));

    p_err_on_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(done_i));

    p_link_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |=> link_up_o);

    p_cmd_with_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (byte_valid_o && link_up_o));

endmodule

// File: rtl/strb_rx.sv
module strb_rx #(
    parameter int         GAP        = 64,
    parameter int         RESP_W     = 32,
    parameter logic [7:0] READY_CODE = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              sink_ready_i,
    output logic [RESP_W-1:0] resp_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic              err_o,
    output logic              link_up_o,
    output logic              cmd_valid_o,
    output logic [4:0]        cmd_sel_o,
    output logic [2:0]        cmd_opt_o
);
    localparam int LEN_W = 3;

    logic             burst_done;
    logic [LEN_W-1:0] burst_len;

    strb_burst_gap #(.GAP(GAP), .LEN_W(LEN_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .done_o   (burst_done),
        .len_o    (burst_len)
    );

    strb_byte_fsm #(.RESP_W(RESP_W), .READY_CODE(READY_CODE)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (burst_done),
        .len_i        (burst_len),
        .sink_ready_i (sink_ready_i),
        .resp_o       (resp_o),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_o),
        .err_o        (err_o),
        .link_up_o    (link_up_o),
        .cmd_valid_o  (cmd_valid_o)
    );

    assign cmd_sel_o = byte_o[7:3];
    assign cmd_opt_o = byte_o[2:0];

endmodule

// File: tb/sim_strb_rx.sv
module sim_strb_rx;
    localparam int GAP    = 64;
    localparam int RESP_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_i = 1'b0;
    logic              sink_ready_i = 1'b1;
    logic [RESP_W-1:0] resp_o;
    logic              byte_valid_o;
    logic [7:0]        byte_o;
    logic              err_o;
    logic              link_up_o;
    logic              cmd_valid_o;
    logic [4:0]        cmd_sel_o;
    logic [2:0]        cmd_opt_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   mon_cnt  = 0;
    logic [7:0] mon_byte = '0;
    logic       mon_cmd  = 1'b0;
    logic [4:0] mon_sel  = '0;
    logic [2:0] mon_opt  = '0;
    bit   finished = 0;

    always #10 clk = ~clk;

    strb_rx #(.GAP(GAP), .RESP_W(RESP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .sink_ready_i(sink_ready_i),
        .resp_o(resp_o), .byte_valid_o(byte_valid_o), .byte_o(byte_o), .err_o(err_o),
        .link_up_o(link_up_o), .cmd_valid_o(cmd_valid_o), .cmd_sel_o(cmd_sel_o),
        .cmd_opt_o(cmd_opt_o)
    );

    always @(negedge clk) begin
        if (rst_n && byte_valid_o) begin
            mon_cnt  = mon_cnt + 1;
            mon_byte = byte_o;
            mon_cmd  = cmd_valid_o;
            mon_sel  = cmd_sel_o;
            mon_opt  = cmd_opt_o;
        end
    end

    function automatic logic [RESP_W-1:0] exp_resp(input bit idle, input bit rdy);
        return (idle && rdy) ? '1 : '0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        strobe_i = 1'b1;
        repeat (hi) @(negedge clk);
        strobe_i = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic burst(input int n, input int hi_max);
        for (int i = 0; i < n; i++) pulse($urandom_range(1, hi_max), $urandom_range(1, 12));
    endtask

    task automatic settle();
        repeat (GAP + 2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb, input int hi_max);
        for (int i = 7; i > 7 - nb; i--) begin
            burst(b[i] ? 1 : 2, hi_max);
            settle();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int hi_max);
        burst(3, 3);
        settle();
        send_bits(b, 8, hi_max);
    endtask

    task automatic expect_byte(input int cnt0, input logic [7:0] b, input bit cmd,
                               input string tag);
        check(mon_cnt == cnt0 + 1, {tag, " byte count"}, mon_cnt, cnt0 + 1);
        check(mon_byte == b, {tag, " byte value"}, mon_byte, b);
        check(mon_cmd == cmd, "R10 cmd_valid", mon_cmd, cmd);
        if (cmd) begin
            check(mon_sel == b[7:3], "R10 cmd_sel", mon_sel, b[7:3]);
            check(mon_opt == b[2:0], "R10 cmd_opt", mon_opt, b[2:0]);
        end
    endtask

    initial begin
        int c0;
        int k;
        bit link_m;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(byte_valid_o == 0, "R1 byte_valid", byte_valid_o, 0);
        check(cmd_valid_o == 0, "R1 cmd_valid", cmd_valid_o, 0);
        check(err_o == 0, "R1 err", err_o, 0);
        check(link_up_o == 0, "R1 link_up", link_up_o, 0);
        check(resp_o == exp_resp(1, 1), "R1 resp", resp_o, exp_resp(1, 1));

        // R8 initial clear in idle, R6 stray bit bursts ignored
        burst(4, 3); settle();
        check(err_o == 0, "R8 err after clear", err_o, 0);
        c0 = mon_cnt;
        burst(1, 3); settle();
        burst(2, 3); settle();
        check(resp_o == exp_resp(1, 1), "R6 still idle", resp_o, exp_resp(1, 1));
        check(mon_cnt == c0, "R6 no byte", mon_cnt, c0);

        // R9 wake-up code, no command yet
        send_byte(8'h90, 3);
        expect_byte(c0, 8'h90, 0, "R9");
        check(link_up_o == 1, "R9 link_up", link_up_o, 1);
        link_m = 1;

        // R2 timing and R4 response during reception, R10 command split
        c0 = mon_cnt;
        burst(3, 3); settle();
        check(resp_o == exp_resp(0, 1), "R4 resp busy", resp_o, exp_resp(0, 1));
        send_bits(8'h3B, 7, 3);
        strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        k = 1;
        while (!byte_valid_o && k < GAP + 10) begin
            @(negedge clk);
            k++;
        end
        check(k == GAP + 1, "R2 valid latency", k, GAP + 1);
        @(negedge clk);
        check(byte_valid_o == 0, "R3 single pulse", byte_valid_o, 0);
        expect_byte(c0, 8'h3B, 1, "R3");
        check(resp_o == exp_resp(1, 1), "R4 resp ready", resp_o, exp_resp(1, 1));

        // R5 not ready: probe ignored
        sink_ready_i = 1'b0;
        @(negedge clk);
        check(resp_o == exp_resp(1, 0), "R4 resp not ready", resp_o, exp_resp(1, 0));
        c0 = mon_cnt;
        send_byte(8'hFF, 3);
        check(mon_cnt == c0, "R5 no byte when not ready", mon_cnt, c0);
        sink_ready_i = 1'b1;
        @(negedge clk);

        // R7 abort by 3 strobes, sticky error
        c0 = mon_cnt;
        burst(3, 3); settle();
        send_bits(8'hA0, 3, 3);
        burst(3, 3); settle();
        check(err_o == 1, "R7 err on probe-length abort", err_o, 1);
        check(mon_cnt == c0, "R7 partial discarded", mon_cnt, c0);
        check(resp_o == exp_resp(1, 1), "R7 back to idle", resp_o, exp_resp(1, 1));
        send_byte(8'h55, 3);
        expect_byte(c0, 8'h55, 1, "R7");
        check(err_o == 1, "R7 err sticky", err_o, 1);
        burst(4, 3); settle();
        check(err_o == 0, "R8 clear err", err_o, 0);

        // R7 abort by 5 strobes
        burst(3, 3); settle();
        send_bits(8'hFF, 2, 3);
        burst(5, 3); settle();
        check(err_o == 1, "R7 err on long burst", err_o, 1);
        burst(4, 3); settle();

        // R8 clear mid-byte then a good byte
        c0 = mon_cnt;
        burst(3, 3); settle();
        send_bits(8'h0F, 4, 3);
        burst(4, 3); settle();
        check(err_o == 0, "R8 no err on clear", err_o, 0);
        check(mon_cnt == c0, "R8 partial discarded", mon_cnt, c0);
        check(resp_o == exp_resp(1, 1), "R8 idle", resp_o, exp_resp(1, 1));
        send_byte(8'hC3, 3);
        expect_byte(c0, 8'hC3, 1, "R8");

        // R11 long strobes count once
        c0 = mon_cnt;
        burst(3, 3); settle();
        for (int i = 7; i >= 0; i--) begin
            for (int j = 0; j < (8'hA5 >> i & 1 ? 1 : 2); j++) pulse(6, 3);
            settle();
        end
        expect_byte(c0, 8'hA5, 1, "R11");

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [7:0] b;
            int mode;
            b = 8'($urandom);
            mode = $urandom_range(0, 4);
            c0 = mon_cnt;
            if (mode == 0) begin
                int ab;
                ab = $urandom_range(0, 2);
                burst(3, 3); settle();
                send_bits(b, $urandom_range(0, 7), 3);
                burst(ab == 0 ? 3 : (ab == 1 ? 5 : 8), 3); settle();
                check(err_o == 1, "R7 random abort", err_o, 1);
                check(mon_cnt == c0, "R7 random discard", mon_cnt, c0);
                burst(4, 3); settle();
                check(err_o == 0, "R8 random clear", err_o, 0);
            end else begin
                send_byte(b, 3);
                expect_byte(c0, b, link_m, "R3 random");
                if (b == 8'h90) link_m = 1;
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule